// File: doc/BRIEF.md
# Debug Module Control Register

This block is the main control word of a debug module. A debugger reaches it over a simple register bus with a write enable, an address, write data and combinational read data. The word selects which hart the debugger addresses. That hart index is split across two fields that are not next to each other, and only a parameterised number of its bits is implemented. The word also carries an optional hart-reset bit, a hart-array-select bit that is tied off when no array mask exists, and a system-reset level that goes out to the rest of the chip.

Three write-only request bits produce one-cycle strobes toward hart control: halt, resume and acknowledge-have-reset. A module-active bit works as a soft reset for the module. While that bit is 0, the clear output holds the abstract-command state (command, error field, auto-execute, program buffer and data words) at zero. A change of the system-reset bit never touches that state.

Top module: `dmControlReg`

## Requirements
- R1: After reset, the control word reads 0x0000_0000, `cmdStateClr` is 1, `hartSel` is 0, and every strobe and level output is 0.
- R2: Bit 0 is the module-active bit. While it is 0, a write changes only bit 0, and the word reads back 0 in bits 31:1.
- R3: Bits 25:16 hold the low part of the hart index. Only min(SEL_W,10) bits are implemented. Writing all ones reads back 2^min(SEL_W,10)-1, and writing 0 reads back 0.
- R4: Bits 15:6 hold the high part of the hart index, with SEL_W-10 bits implemented. `hartSel` equals {high part, low part}.
- R5: Bit 29 is the hart-reset bit. When HAS_HART_RST=1 it reads back as written and drives `hartReset`. Otherwise it reads 0.
- R6: Bit 26 is the hart-array-select bit. When HAS_ARRAY_SEL=0 (the default) a written 1 reads back 0, and `hartArraySel` stays 0.
- R7: A write of bit 31 while active, with bit 0 also 1, raises `haltPulse` for exactly the cycle after the write edge. Bit 31 always reads 0.
- R8: Bit 30 behaves the same way for `resumePulse`, and always reads 0.
- R9: Bit 28 behaves the same way for `ackResetPulse`, and always reads 0.
- R10: Bit 1 is a read/write system-reset level driven on `sysReset`. Setting it and then clearing it leaves `cmdStateClr` at 0.
- R11: A write with bit 0 at 0 sets `cmdStateClr` to 1 from the next cycle. It clears every field and raises no strobe, even when request bits are set in the same write.
- R12: Writes to any address other than CTRL_ADDR change nothing and raise no strobe. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one bus cycle |
| addr | input | ADDR_W | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| hartSel | output | SEL_W | Selected hart index |
| hartArraySel | output | 1 | Hart-array-select level |
| hartReset | output | 1 | Hart-reset level |
| haltPulse | output | 1 | One-cycle halt request |
| resumePulse | output | 1 | One-cycle resume request |
| ackResetPulse | output | 1 | One-cycle have-reset acknowledge |
| sysReset | output | 1 | System reset level |
| cmdStateClr | output | 1 | Holds abstract-command state at zero while 1 |

## Verification
The soft-reset clear and the request strobes can both be called for by one write. A write of 0xFFFF_FFFE carries all three request bits and also drops the active bit. The bench checks that this write raises `cmdStateClr`, zeroes every field and fires no strobe, which shows the clear taking priority. The reverse case also occurs in one cycle: the first write of 0x23FF_00C3 after deactivation only sets the active bit. Field loads, active-bit changes and pulses are all judged at the negative edge that follows each write.

// File: rtl/dmCtrlPkg.sv
package dmCtrlPkg;
  localparam int HALT_BIT   = 31;
  localparam int RESUME_BIT = 30;
  localparam int HRST_BIT   = 29;
  localparam int ACK_BIT    = 28;
  localparam int ASEL_BIT   = 26;
  localparam int LO_POS     = 16;
  localparam int HI_POS     = 6;
  localparam int FLD_W      = 10;
  localparam int SYSRST_BIT = 1;
  localparam int ACTIVE_BIT = 0;

  typedef struct packed {
    logic ldAct;
    logic actVal;
    logic ldFld;
    logic clrFld;
    logic halt;
    logic resume;
    logic ack;
  } dmStrobe_t;
endpackage

// File: rtl/dmCtrlDecode.sv
module dmCtrlDecode
  import dmCtrlPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              active,
  output dmStrobe_t         strobe
);
  logic hit;
  logic goOn;
  logic live;

  always_comb begin
    hit  = wrEn && (addr == CTRL_ADDR);
    goOn = wrData[ACTIVE_BIT];
    live = hit && active && goOn;
    strobe.ldAct  = hit;
    strobe.actVal = goOn;
    strobe.clrFld = hit && !goOn;
    strobe.ldFld  = live;
    strobe.halt   = live && wrData[HALT_BIT];
    strobe.resume = live && wrData[RESUME_BIT];
    strobe.ack    = live && wrData[ACK_BIT];
  end
endmodule

// File: rtl/dmCtrlRegs.sv
module dmCtrlRegs
  import dmCtrlPkg::*;
#(
  parameter int SEL_W = 12,
  parameter bit HAS_HART_RST = 1'b1,
  parameter bit HAS_ARRAY_SEL = 1'b0,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmStrobe_t         strobe,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic [31:0]       rdData,
  output logic [SEL_W-1:0]  hartSel,
  output logic              arraySel,
  output logic              hartReset,
  output logic              sysReset,
  output logic              haltPulse,
  output logic              resumePulse,
  output logic              ackPulse
);
  localparam int LO_W = (SEL_W > FLD_W) ? FLD_W : SEL_W;
  localparam int HI_W = (SEL_W > FLD_W) ? SEL_W - FLD_W : 0;

  logic [LO_W-1:0]  selLo;
  logic [FLD_W-1:0] selLoFld;
  logic [FLD_W-1:0] selHiFld;
  logic [31:0]      word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active      <= 1'b0;
      sysReset    <= 1'b0;
      selLo       <= '0;
      haltPulse   <= 1'b0;
      resumePulse <= 1'b0;
      ackPulse    <= 1'b0;
    end else begin
      haltPulse   <= strobe.halt;
      resumePulse <= strobe.resume;
      ackPulse    <= strobe.ack;
      if (strobe.ldAct) active <= strobe.actVal;
      if (strobe.clrFld) begin
        sysReset <= 1'b0;
        selLo    <= '0;
      end else if (strobe.ldFld) begin
        sysReset <= wrData[SYSRST_BIT];
        selLo    <= wrData[LO_POS +: LO_W];
      end
    end
  end

  assign selLoFld = FLD_W'(selLo);

  generate
    if (HI_W > 0) begin : gHi
      logic [HI_W-1:0] selHi;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              selHi <= '0;
        else if (strobe.clrFld) selHi <= '0;
        else if (strobe.ldFld)  selHi <= wrData[HI_POS +: HI_W];
      end
      assign selHiFld = FLD_W'(selHi);
      assign hartSel  = {selHi, selLo};
    end else begin : gNoHi
      assign selHiFld = '0;
      assign hartSel  = selLo;
    end

    if (HAS_HART_RST) begin : gHrst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              hartReset <= 1'b0;
        else if (strobe.clrFld) hartReset <= 1'b0;
        else if (strobe.ldFld)  hartReset <= wrData[HRST_BIT];
      end
    end else begin : gNoHrst
      assign hartReset = 1'b0;
    end

    if (HAS_ARRAY_SEL) begin : gAsel
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              arraySel <= 1'b0;
        else if (strobe.clrFld) arraySel <= 1'b0;
        else if (strobe.ldFld)  arraySel <= wrData[ASEL_BIT];
      end
    end else begin : gNoAsel
      assign arraySel = 1'b0;
    end
  endgenerate

  always_comb begin
    word                           = '0;
    word[HRST_BIT]                 = hartReset;
    word[ASEL_BIT]                 = arraySel;
    word[LO_POS +: FLD_W]          = selLoFld;
    word[HI_POS +: FLD_W]          = selHiFld;
    word[SYSRST_BIT]               = sysReset;
    word[ACTIVE_BIT]               = active;
    rdData = (addr == CTRL_ADDR) ? word : 32'h0;
  end
endmodule

// File: rtl/dmControlReg.sv
module dmControlReg
  import dmCtrlPkg::*;
#(
  parameter int SEL_W = 12,
  parameter bit HAS_HART_RST = 1'b1,
  parameter bit HAS_ARRAY_SEL = 1'b0,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [SEL_W-1:0]  hartSel,
  output logic              hartArraySel,
  output logic              hartReset,
  output logic              haltPulse,
  output logic              resumePulse,
  output logic              ackResetPulse,
  output logic              sysReset,
  output logic              cmdStateClr
);
  dmStrobe_t strobe;
  logic      active;

  dmCtrlDecode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) uDecode (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .active(active), .strobe(strobe)
  );

  dmCtrlRegs #(
    .SEL_W(SEL_W), .HAS_HART_RST(HAS_HART_RST), .HAS_ARRAY_SEL(HAS_ARRAY_SEL),
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .addr(addr),
    .active(active), .rdData(rdData), .hartSel(hartSel), .arraySel(hartArraySel),
    .hartReset(hartReset), .sysReset(sysReset), .haltPulse(haltPulse),
    .resumePulse(resumePulse), .ackPulse(ackResetPulse)
  );

  assign cmdStateClr = ~active;
endmodule

// File: rtl/dmControlRegChecks.sv
module dmControlRegChecks #(
  parameter int SEL_W = 12,
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic [SEL_W-1:0]  hartSel,
  input logic              haltPulse,
  input logic              resumePulse,
  input logic              ackResetPulse,
  input logic              cmdStateClr
);
  logic ctrlWr;
  assign ctrlWr = wrEn && (addr == CTRL_ADDR);

  // R7: a halt strobe only follows an active write carrying the halt bit
  a_r7_halt_cause: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> $past(ctrlWr && wrData[31] && wrData[0] && !cmdStateClr));

  // R8
  a_r8_resume_cause: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> $past(ctrlWr && wrData[30] && wrData[0] && !cmdStateClr));

  // R9
  a_r9_ack_cause: assert property (@(posedge clk) disable iff (!rstN)
    ackResetPulse |-> $past(ctrlWr && wrData[28] && wrData[0] && !cmdStateClr));

  // R11: the clear only rises after a write dropping the active bit
  a_r11_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdStateClr) |-> $past(ctrlWr && !wrData[0]));

  // R10: active writes, whatever the system-reset bit, keep the clear low
  a_r10_sysrst_keeps_state: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && wrData[0] && !cmdStateClr) |=> !cmdStateClr);

  // R12: no control write, no change of the hart index
  a_r12_sel_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(hartSel));

  // R2: inactive module reads zero above the active bit
  a_r2_inactive_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStateClr && addr == CTRL_ADDR) |-> (rdData[31:1] == 31'h0));
endmodule

bind dmControlReg dmControlRegChecks #(
  .SEL_W(SEL_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) uChecks (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .hartSel(hartSel), .haltPulse(haltPulse),
  .resumePulse(resumePulse), .ackResetPulse(ackResetPulse),
  .cmdStateClr(cmdStateClr)
);

// File: tb/test_dmControlReg.sv
module test_dmControlReg;
  localparam logic [6:0] CTRL = 7'h10;
  localparam logic [6:0] OTHER = 7'h11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  addr = CTRL;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [11:0] hartSel;
  logic        hartArraySel, hartReset, haltPulse, resumePulse, ackResetPulse;
  logic        sysReset, cmdStateClr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmControlReg i_dmControlReg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hartSel(hartSel), .hartArraySel(hartArraySel),
    .hartReset(hartReset), .haltPulse(haltPulse), .resumePulse(resumePulse),
    .ackResetPulse(ackResetPulse), .sysReset(sysReset), .cmdStateClr(cmdStateClr)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [31:0] data;
    logic [31:0] rd;
    logic [11:0] sel;
    logic        hr;
    logic        sys;
    logic        clr;
    logic        halt;
    logic        res;
    logic        ack;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{"R2 ", 32'h03FF_FFC2, 32'h0000_0000, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{"R2 ", 32'h0000_0001, 32'h0000_0001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R3 ", 32'h03FF_0001, 32'h03FF_0001, 12'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R4 ", 32'h0000_FFC1, 32'h0000_00C1, 12'hC00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R4 ", 32'h0155_0041, 32'h0155_0041, 12'h555, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R5 ", 32'h2000_0001, 32'h2000_0001, 12'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R6 ", 32'h0400_0001, 32'h0000_0001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R10", 32'h0000_0003, 32'h0000_0003, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{"R7 ", 32'hD000_0001, 32'h0000_0001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R3 ", 32'hFFFF_FFFF, 32'h23FF_00C3, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{"R11", 32'hFFFF_FFFE, 32'h0000_0000, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{"R2 ", 32'h23FF_00C3, 32'h0000_0001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input logic [23:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at the falling edge, return one falling edge later with outputs settled
  task automatic doWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = CTRL;
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 ", "rdData", rdData, 32'h0);
    chk("R1 ", "cmdStateClr", 32'(cmdStateClr), 32'h1);
    chk("R1 ", "hartSel", 32'(hartSel), 32'h0);
    chk("R1 ", "levels", {28'h0, sysReset, hartReset, hartArraySel, haltPulse}, 32'h0);

    foreach (VECS[i]) begin
      doWrite(CTRL, VECS[i].data);
      chk(VECS[i].tag, "rdData", rdData, VECS[i].rd);
      chk("R4 ", "hartSel", 32'(hartSel), 32'(VECS[i].sel));
      chk("R5 ", "hartReset", 32'(hartReset), 32'(VECS[i].hr));
      chk("R6 ", "hartArraySel", 32'(hartArraySel), 32'h0);
      chk("R10", "sysReset", 32'(sysReset), 32'(VECS[i].sys));
      chk("R11", "cmdStateClr", 32'(cmdStateClr), 32'(VECS[i].clr));
      chk("R7 ", "haltPulse", 32'(haltPulse), 32'(VECS[i].halt));
      chk("R8 ", "resumePulse", 32'(resumePulse), 32'(VECS[i].res));
      chk("R9 ", "ackResetPulse", 32'(ackResetPulse), 32'(VECS[i].ack));
      @(negedge clk); #1;
      chk("R7 ", "halt pulse width", 32'(haltPulse), 32'h0);
      chk("R8 ", "resume pulse width", 32'(resumePulse), 32'h0);
      chk("R9 ", "ack pulse width", 32'(ackResetPulse), 32'h0);
    end

    // R3: zero written to the low field reads back zero
    doWrite(CTRL, 32'h0000_0001);
    chk("R3 ", "low field zero", rdData, 32'h0000_0001);

    // R10: set then release system reset, command state never cleared
    doWrite(CTRL, 32'h0155_0043);
    chk("R10", "sysReset set", 32'(sysReset), 32'h1);
    chk("R10", "clr during sysReset", 32'(cmdStateClr), 32'h0);
    doWrite(CTRL, 32'h0155_0041);
    chk("R10", "sysReset released", 32'(sysReset), 32'h0);
    chk("R10", "clr after release", 32'(cmdStateClr), 32'h0);
    chk("R10", "fields kept", rdData, 32'h0155_0041);

    // R12: other address ignored, reads 0 there
    doWrite(OTHER, 32'hFFFF_FFFE);
    chk("R12", "no halt strobe", 32'(haltPulse), 32'h0);
    chk("R12", "ctrl unchanged", rdData, 32'h0155_0041);
    chk("R12", "clr unchanged", 32'(cmdStateClr), 32'h0);
    addr = OTHER;
    #1;
    chk("R12", "other read", rdData, 32'h0);
    addr = CTRL;

    // R7: halt alone while active
    doWrite(CTRL, 32'h8155_0041);
    chk("R7 ", "halt only", {29'h0, haltPulse, resumePulse, ackResetPulse}, 32'h4);
    chk("R7 ", "halt not readable", rdData, 32'h0155_0041);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule